// File: doc/BRIEF.md
# UART Flow Control and Multidrop Gate

This block sits between a UART's byte transmitter/receiver and the surrounding data paths. On the receive side it takes each received byte as a valid/ready stream, decides whether the byte is forwarded, consumed as a control byte, or discarded, and tracks the resulting flow-control or address state. On the transmit side it grants the start of each new byte (`tx_start`) from a pending request, the transmitter's busy flag and the current mode. It also drives the RTS handshake output.

An 8-bit control input selects the behaviour. Bits 2:0 hold the mode: 0 = pass-through, 1 = hardware handshake, 2 = XON/XOFF software flow, 3 = multidrop with receive gated by address match, 4 = multidrop with both directions gated. Bit 3 enables half-duplex receive blanking. Two 8-bit character inputs act as the XON/XOFF pair in mode 2 and as the set/clear address pair in modes 3 and 4.

Receive back-pressure rules: a byte that is forwarded is accepted (`rx_in_ready`) only when the downstream side is ready (`rx_out_ready`). A byte that is consumed or discarded is accepted at once, whatever `rx_out_ready` is. State changes only on an accepted byte.

Top module: `uart_flow_gate`

## Requirements
- R1: Mode values 5, 6 and 7 behave exactly as mode 0. Control bits 7:4 have no effect, and changing only those bits does not count as a mode change.
- R2: In mode 0 every received byte is forwarded unchanged, and `tx_start` equals `tx_req` and not `tx_busy`, whatever `cts` is.
- R3: In mode 1 `tx_start` is asserted only while `cts` is 1, and `rts` follows `rx_space`. In every other mode `rts` is 1.
- R4: In mode 2 a received byte equal to `char_b` (XOFF) suspends transmit starts from the next cycle on. A byte equal to `char_a` (XON) resumes them from the next cycle on. Neither byte is forwarded. If both characters are equal, the XOFF meaning wins.
- R5: `tx_start` is never asserted while `tx_busy` is 1. A byte in flight is therefore never cut off, and a suspension takes effect at the next byte boundary.
- R6: In mode 3 a non-address byte is forwarded only while the matched state is set, and `tx_start` ignores the matched state.
- R7: In mode 4 non-address bytes are forwarded and `tx_start` is granted only while the matched state is set.
- R8: In modes 3 and 4 a byte equal to `char_a` sets the matched state, and a byte equal to `char_b` clears it (clear wins if both are equal). Address bytes are never forwarded.
- R9: With control bit 3 set, a byte received while `tx_busy` is 1 is accepted, not forwarded, and changes no state. With bit 3 clear, bytes are forwarded while transmitting.
- R10: Reset, or a change of the effective mode, clears the suspended and matched states in the same cycle the new mode is seen.
- R11: `rx_out_data` equals `rx_in_data`, and `rx_out_valid` implies `rx_in_valid`. A forwarded byte is accepted only when `rx_out_ready` is 1. A consumed or discarded byte is accepted regardless of `rx_out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl | input | 8 | Bits 2:0 mode, bit 3 half-duplex, 7:4 ignored |
| char_a | input | 8 | XON character / address-set value |
| char_b | input | 8 | XOFF character / address-clear value |
| rx_in_valid | input | 1 | Received byte available |
| rx_in_data | input | 8 | Received byte |
| rx_in_ready | output | 1 | Received byte accepted |
| rx_out_valid | output | 1 | Filtered byte available |
| rx_out_data | output | 8 | Filtered byte |
| rx_out_ready | input | 1 | Downstream can take a byte |
| tx_req | input | 1 | A transmit byte is waiting |
| tx_busy | input | 1 | Transmitter is shifting a byte |
| tx_start | output | 1 | Transmitter may start the next byte |
| cts | input | 1 | Clear-to-send from the far end, 1 = asserted |
| rx_space | input | 1 | Local receive path can take more data |
| rts | output | 1 | Request-to-send to the far end, 1 = asserted |

## Verification
On every cycle, the assertions check the stream invariants (data passthrough, valid implies valid, acceptance under back-pressure), the ban on starting while busy, CTS gating and RTS following in mode 1, and blanking in half-duplex. They also check that an accepted XOFF in mode 2, or an accepted clear address in mode 4, blocks `tx_start` in the following cycle. Only the bench scenarios can show the rest: the full ordering of suspend/resume and match/clear sequences, the aliasing of modes 5 to 7, that reserved bits are ignored while state is kept, clearing on a mode change and on reset, and that a blanked XOFF leaves transmit running.

// File: rtl/uart_fg_pkg.sv
package uart_fg_pkg;
  localparam int CTRL_W  = 8;
  localparam int MODE_W  = 3;
  localparam int HDX_BIT = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_NONE    = 3'd0,
    MODE_HW      = 3'd1,
    MODE_SW      = 3'd2,
    MODE_MD_RX   = 3'd3,
    MODE_MD_BOTH = 3'd4
  } fg_mode_e;
endpackage

// File: rtl/uart_fg_decode.sv
module uart_fg_decode
  import uart_fg_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  output fg_mode_e          mode,
  output logic              hdx
);
  logic [MODE_W-1:0] raw;
  assign raw = ctrl[MODE_W-1:0];
  assign hdx = ctrl[HDX_BIT];

  // values above the last defined mode fall back to pass-through
  always_comb begin
    if (raw > MODE_MD_BOTH) mode = MODE_NONE;
    else                    mode = fg_mode_e'(raw);
  end
endmodule

// File: rtl/uart_fg_rx_filter.sv
module uart_fg_rx_filter
  import uart_fg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fg_mode_e          mode,
  input  logic              hdx,
  input  logic              tx_busy,
  input  logic [DATA_W-1:0] char_a,
  input  logic [DATA_W-1:0] char_b,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              suspended,
  output logic              matched
);
  fg_mode_e mode_q;
  logic     sus_q, mat_q;
  logic     same_mode, sus_cur, mat_cur;
  logic     sus_nx, mat_nx, fwd, blank, hit_a, hit_b, take;

  // a mode change clears state in the very cycle it is seen
  assign same_mode = (mode == mode_q);
  assign sus_cur   = sus_q & same_mode;
  assign mat_cur   = mat_q & same_mode;
  assign blank     = hdx & tx_busy;
  assign hit_a     = (in_data == char_a);
  assign hit_b     = (in_data == char_b);

  always_comb begin
    sus_nx = sus_cur;
    mat_nx = mat_cur;
    fwd    = 1'b1;
    if (blank) begin
      fwd = 1'b0;
    end else begin
      case (mode)
        MODE_SW: begin
          if (hit_b) begin
            fwd    = 1'b0;
            sus_nx = 1'b1;
          end else if (hit_a) begin
            fwd    = 1'b0;
            sus_nx = 1'b0;
          end
        end
        MODE_MD_RX, MODE_MD_BOTH: begin
          if (hit_b) begin
            fwd    = 1'b0;
            mat_nx = 1'b0;
          end else if (hit_a) begin
            fwd    = 1'b0;
            mat_nx = 1'b1;
          end else begin
            fwd    = mat_cur;
          end
        end
        default: fwd = 1'b1;
      endcase
    end
  end

  assign out_valid = in_valid & fwd;
  assign in_ready  = fwd ? out_ready : 1'b1;
  assign take      = in_valid & in_ready;
  assign suspended = sus_cur;
  assign matched   = mat_cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_NONE;
      sus_q  <= 1'b0;
      mat_q  <= 1'b0;
    end else begin
      mode_q <= mode;
      sus_q  <= take ? sus_nx : sus_cur;
      mat_q  <= take ? mat_nx : mat_cur;
    end
  end
endmodule

// File: rtl/uart_fg_tx_gate.sv
module uart_fg_tx_gate
  import uart_fg_pkg::*;
(
  input  fg_mode_e mode,
  input  logic     suspended,
  input  logic     matched,
  input  logic     cts,
  input  logic     rx_space,
  input  logic     tx_req,
  input  logic     tx_busy,
  output logic     tx_start,
  output logic     rts
);
  logic allow;

  always_comb begin
    case (mode)
      MODE_HW:      allow = cts;
      MODE_SW:      allow = ~suspended;
      MODE_MD_BOTH: allow = matched;
      default:      allow = 1'b1;
    endcase
  end

  // grants only at a byte boundary, so a byte in flight always completes
  assign tx_start = tx_req & ~tx_busy & allow;
  assign rts      = (mode == MODE_HW) ? rx_space : 1'b1;
endmodule

// File: rtl/uart_flow_gate.sv
module uart_flow_gate
  import uart_fg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [DATA_W-1:0] char_a,
  input  logic [DATA_W-1:0] char_b,
  input  logic              rx_in_valid,
  input  logic [DATA_W-1:0] rx_in_data,
  output logic              rx_in_ready,
  output logic              rx_out_valid,
  output logic [DATA_W-1:0] rx_out_data,
  input  logic              rx_out_ready,
  input  logic              tx_req,
  input  logic              tx_busy,
  output logic              tx_start,
  input  logic              cts,
  input  logic              rx_space,
  output logic              rts
);
  fg_mode_e mode;
  logic     hdx, suspended, matched;

  uart_fg_decode u_decode (
    .ctrl (ctrl),
    .mode (mode),
    .hdx  (hdx)
  );

  uart_fg_rx_filter #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .hdx       (hdx),
    .tx_busy   (tx_busy),
    .char_a    (char_a),
    .char_b    (char_b),
    .in_valid  (rx_in_valid),
    .in_data   (rx_in_data),
    .in_ready  (rx_in_ready),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .suspended (suspended),
    .matched   (matched)
  );

  assign rx_out_data = rx_in_data;

  uart_fg_tx_gate u_tx (
    .mode      (mode),
    .suspended (suspended),
    .matched   (matched),
    .cts       (cts),
    .rx_space  (rx_space),
    .tx_req    (tx_req),
    .tx_busy   (tx_busy),
    .tx_start  (tx_start),
    .rts       (rts)
  );
endmodule

// File: rtl/uart_flow_gate_chk.sv
module uart_flow_gate_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        ctrl,
  input logic [DATA_W-1:0] char_a,
  input logic [DATA_W-1:0] char_b,
  input logic              rx_in_valid,
  input logic [DATA_W-1:0] rx_in_data,
  input logic              rx_in_ready,
  input logic              rx_out_valid,
  input logic [DATA_W-1:0] rx_out_data,
  input logic              rx_out_ready,
  input logic              tx_req,
  input logic              tx_busy,
  input logic              tx_start,
  input logic              cts,
  input logic              rx_space,
  input logic              rts
);
  // R5
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (tx_req && !tx_busy));

  // R3
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[2:0] == 3'd1 && !cts) |-> !tx_start);

  // R3
  rts_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[2:0] == 3'd1) |-> (rts == rx_space));

  // R9
  hdx_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[3] && tx_busy) |-> !rx_out_valid);

  // R11
  out_implies_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid |-> (rx_in_valid && rx_out_data == rx_in_data));

  // R11
  fwd_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid |-> (rx_in_ready == rx_out_ready));

  // R4
  xoff_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ctrl[2:0] == 3'd2 && rx_in_valid && rx_in_ready
       && rx_in_data == char_b && !(ctrl[3] && tx_busy))
     && ctrl == $past(ctrl)) |-> !tx_start);

  // R7
  unmatch_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ctrl[2:0] == 3'd4 && rx_in_valid && rx_in_ready
       && rx_in_data == char_b && !(ctrl[3] && tx_busy))
     && ctrl == $past(ctrl)) |-> !tx_start);
endmodule

bind uart_flow_gate uart_flow_gate_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/uart_flow_gate_bench.sv
module uart_flow_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CA = 8'h11;
  localparam logic [7:0] CB = 8'h13;
  localparam int NV = 25;

  // {ctrl, data, busy, cts, exp_rx_out_valid, exp_tx_start}
  localparam logic [19:0] VEC [NV] = '{
    {8'h00, 8'h41, 1'b0, 1'b0, 1'b1, 1'b1},  // R2
    {8'h00, 8'h13, 1'b0, 1'b0, 1'b1, 1'b1},  // R2
    {8'h01, 8'h42, 1'b0, 1'b0, 1'b1, 1'b0},  // R3
    {8'h01, 8'h43, 1'b0, 1'b1, 1'b1, 1'b1},  // R3
    {8'h02, 8'h13, 1'b0, 1'b1, 1'b0, 1'b1},  // R4 xoff
    {8'h02, 8'h44, 1'b0, 1'b1, 1'b1, 1'b0},  // R4
    {8'h02, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0},  // R4 xon
    {8'h02, 8'h45, 1'b0, 1'b1, 1'b1, 1'b1},  // R4
    {8'h03, 8'h46, 1'b0, 1'b1, 1'b0, 1'b1},  // R6
    {8'h03, 8'h11, 1'b0, 1'b1, 1'b0, 1'b1},  // R8
    {8'h03, 8'h47, 1'b0, 1'b1, 1'b1, 1'b1},  // R6
    {8'h03, 8'h13, 1'b0, 1'b1, 1'b0, 1'b1},  // R8
    {8'h03, 8'h48, 1'b0, 1'b1, 1'b0, 1'b1},  // R8
    {8'h04, 8'h49, 1'b0, 1'b1, 1'b0, 1'b0},  // R7
    {8'h04, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0},  // R7
    {8'h04, 8'h4A, 1'b0, 1'b1, 1'b1, 1'b1},  // R7
    {8'hF4, 8'h4B, 1'b0, 1'b1, 1'b1, 1'b1},  // R1 reserved bits
    {8'h05, 8'h13, 1'b0, 1'b0, 1'b1, 1'b1},  // R1 alias
    {8'h08, 8'h4D, 1'b1, 1'b0, 1'b0, 1'b0},  // R9
    {8'h08, 8'h4E, 1'b0, 1'b0, 1'b1, 1'b1},  // R9
    {8'h00, 8'h4F, 1'b1, 1'b0, 1'b1, 1'b0},  // R9 R5
    {8'h0A, 8'h13, 1'b1, 1'b0, 1'b0, 1'b0},  // R9
    {8'h0A, 8'h50, 1'b0, 1'b0, 1'b1, 1'b1},  // R9 xoff ignored
    {8'h04, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0},  // R10
    {8'h03, 8'h51, 1'b0, 1'b0, 1'b0, 1'b1}   // R10 cleared
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic [7:0] char_a = CA, char_b = CB;
  logic       rx_in_valid = 1'b0;
  logic [7:0] rx_in_data = 8'h00;
  logic       rx_in_ready, rx_out_valid;
  logic [7:0] rx_out_data;
  logic       rx_out_ready = 1'b1;
  logic       tx_req = 1'b0, tx_busy = 1'b0, tx_start;
  logic       cts = 1'b0, rx_space = 1'b0, rts;
  int         n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_flow_gate u_uart_flow_gate (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] c, input logic [7:0] d, input logic v,
                       input logic b, input logic ct);
    @(negedge clk);
    ctrl = c; rx_in_data = d; rx_in_valid = v; tx_busy = b; cts = ct;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R10 reset state
    check("R10 reset rx_out_valid", {7'b0, rx_out_valid}, 8'h0);
    check("R10 reset tx_start", {7'b0, tx_start}, 8'h0);
    check("R3 reset rts", {7'b0, rts}, 8'h1);

    tx_req = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][19:12], VEC[i][11:4], 1'b1, VEC[i][3], VEC[i][2]);
      check($sformatf("vec%0d rx_out_valid", i), {7'b0, rx_out_valid}, {7'b0, VEC[i][1]});
      check($sformatf("vec%0d tx_start", i), {7'b0, tx_start}, {7'b0, VEC[i][0]});
      if (VEC[i][1]) check("R11 data", rx_out_data, VEC[i][11:4]);
      check("R3 rts", {7'b0, rts}, (VEC[i][14:12] == 3'd1) ? {7'b0, rx_space} : 8'h1);
    end

    // R3 rts follows rx_space in mode 1
    rx_space = 1'b1;
    drive(8'h01, 8'h00, 1'b0, 1'b0, 1'b1);
    check("R3 rts high", {7'b0, rts}, 8'h1);
    rx_space = 1'b0; #1;
    check("R3 rts low", {7'b0, rts}, 8'h0);

    // R11 back-pressure on a forwarded byte
    rx_out_ready = 1'b0;
    drive(8'h00, 8'h60, 1'b1, 1'b0, 1'b0);
    check("R11 fwd stalled ready", {7'b0, rx_in_ready}, 8'h0);
    // R11 consumed byte accepted under back-pressure
    drive(8'h02, CB, 1'b1, 1'b0, 1'b0);
    check("R11 consumed ready", {7'b0, rx_in_ready}, 8'h1);
    drive(8'h02, 8'h61, 1'b0, 1'b0, 1'b0);
    check("R4 suspended after xoff", {7'b0, tx_start}, 8'h0);
    rx_out_ready = 1'b1;

    // R5 busy transmitter: no start even when allowed
    drive(8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    check("R5 no start while busy", {7'b0, tx_start}, 8'h0);

    // R10 reset clears suspension
    drive(8'h02, CB, 1'b1, 1'b0, 1'b0);
    @(negedge clk); rx_in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check("R10 cleared by reset", {7'b0, tx_start}, 8'h1);

    // R4 equal characters: XOFF meaning wins
    char_a = 8'h22; char_b = 8'h22;
    drive(8'h02, 8'h22, 1'b1, 1'b0, 1'b0);
    drive(8'h02, 8'h62, 1'b0, 1'b0, 1'b0);
    check("R4 equal chars suspend", {7'b0, tx_start}, 8'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule